// File: doc/BRIEF.md
# Local-to-VMEbus Window Decoder

This block decides, for each local bus access, which VMEbus window serves it and with what cycle attributes. Software sets up four programmable windows through a small write-only register port. Each window has its own address range, address space (A24 or A32), data width (D16 or D32), write-posting policy and privilege and program/data attributes. A fixed I/O decoder sits above them with its own enable. It covers three hard-wired regions: short I/O (A16), an A24/D16 region and an A32/D16 region.

An access is presented as an address, a write flag and a valid strobe. One clock later the block reports whether a window matched, which one it was, the address space, the resulting 6-bit VMEbus address modifier, the data width, the privilege and program attributes, and whether the write may be posted. Bus arbitration, cycle timing and data steering belong to the blocks downstream.

Top module: `bus_window_map`

## Requirements
- R1: Programmable window i hits when its enable bit is set and lo_i <= acc_addr[31:16] <= hi_i, both bounds inclusive; a window whose lo is above its hi never hits.
- R2: When several programmable windows hit, the lowest-numbered one supplies every output.
- R3: With the fixed I/O decoder enabled, an address inside any of its regions is claimed by it even when a programmable window also covers it; with it disabled, those addresses go to the programmable windows.
- R4: Addresses 0xFFFF0000 to 0xFFFFFFFF map to A16 space, with D32 when the fixed decoder's width bit is 1 and D16 when it is 0.
- R5: Addresses 0xF0000000 to 0xF0FFFFFF map to A24/D16, and 0xF1000000 to 0xFF7FFFFF map to A32/D16; 0xFF800000 to 0xFFFEFFFF is not fixed I/O.
- R6: vme_am is 0x08/0x38/0x28 for A32/A24/A16, plus 0x04 when supervisor, plus 0x02 for program or 0x01 for data in A24/A32; A16 always adds 0x01, so the program bit has no effect there.
- R7: post_wr is 1 only for a hitting write whose selected decoder has posting enabled; reads never post.
- R8: Outputs are registered: the result for an access with acc_valid high appears on the cycle after it. A cycle without acc_valid, or a miss, gives hit=0 and all attribute outputs 0.
- R9: Register map: cfg_addr 2i holds {hi_i, lo_i} in bits [31:16] and [15:0]. cfg_addr 2i+1 holds the attributes of window i: bit0 enable, bit1 A32 (0 gives A24), bit2 D32, bit3 posting, bit4 supervisor, bit5 program. cfg_addr 8 holds the same layout for the fixed decoder, with bit2 setting the short I/O width and bit1 unused. After reset every decoder is disabled.
- R10: hit_win gives the index of the hitting programmable window, 4 for the fixed decoder, and 0 on a miss; vme_space encodes A16=0, A24=1, A32=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access address is valid this cycle |
| acc_addr | input | 32 | Local access address |
| acc_write | input | 1 | Access is a write |
| hit | output | 1 | Some enabled decoder matched |
| hit_win | output | 3 | Matching decoder index, 4 = fixed I/O |
| vme_space | output | 2 | Address space: 0 A16, 1 A24, 2 A32 |
| vme_am | output | 6 | VMEbus address modifier code |
| vme_d32 | output | 1 | 1 = D32, 0 = D16 |
| vme_sup | output | 1 | Supervisor access |
| vme_prog | output | 1 | Program space access |
| post_wr | output | 1 | Write may be posted |

## Verification
The bench probes both inclusive ends of each range and the single-step windows just outside them. A comparator off by one would drop the last block of a window or claim its neighbour. It overlaps windows 0 and 1 and later disables window 0, which exposes a reversed priority or a priority that ignores the enable bit. It hits fixed regions that a programmable window also covers, with the fixed decoder on and then off, and probes the gap between the fixed A32 region and short I/O. A wrong precedence or a loose region compare would then return the wrong window index or space. Reads to posting windows, program-space short I/O accesses and an inverted window check that posting never reaches reads, that the A16 code ignores the program bit, and that a window with lo above hi stays silent.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic [1:0] {
    SPC_A16 = 2'd0,
    SPC_A24 = 2'd1,
    SPC_A32 = 2'd2
  } space_e;

  // bit0 en, bit1 a32, bit2 d32, bit3 post, bit4 sup, bit5 prog
  typedef struct packed {
    logic prog;
    logic sup;
    logic post;
    logic d32;
    logic a32;
    logic en;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  localparam logic [15:0] SHORT_IO_TAG = 16'hFFFF;
  localparam logic [7:0]  FIX_A24_TAG  = 8'hF0;
  localparam logic [31:0] FIX_A32_LO   = 32'hF100_0000;
  localparam logic [31:0] FIX_A32_HI   = 32'hFF7F_FFFF;

  function automatic logic [5:0] am_code(space_e spc, logic sup, logic prog);
    logic [5:0] base;
    logic [1:0] kind;
    case (spc)
      SPC_A32: base = 6'h08;
      SPC_A24: base = 6'h38;
      default: base = 6'h28;
    endcase
    if (spc == SPC_A16) kind = 2'b01;
    else                kind = prog ? 2'b10 : 2'b01;
    return base | {3'b000, sup, kind};
  endfunction

endpackage

// File: rtl/bwm_cfg_regs.sv
module bwm_cfg_regs
  import bwm_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int CMP_BITS = 16,
  parameter int CFG_AW   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [CFG_AW-1:0]                  cfg_addr,
  input  logic [2*CMP_BITS-1:0]              cfg_wdata,
  output logic [NUM_WIN-1:0][CMP_BITS-1:0]   win_lo,
  output logic [NUM_WIN-1:0][CMP_BITS-1:0]   win_hi,
  output attr_t [NUM_WIN-1:0]                win_attr,
  output attr_t                              fix_attr
);

  localparam int DW      = 2 * CMP_BITS;
  localparam int FIX_IDX = 2 * NUM_WIN;

  logic [NUM_WIN-1:0][DW-1:0] range_q, range_d;
  attr_t [NUM_WIN-1:0]        attr_q, attr_d;
  attr_t                      fix_q, fix_d;

  always_comb begin
    range_d = range_q;
    attr_d  = attr_q;
    fix_d   = fix_q;
    if (cfg_we) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (int'(cfg_addr) == 2*i)     range_d[i] = cfg_wdata;
        if (int'(cfg_addr) == 2*i + 1) attr_d[i]  = attr_t'(cfg_wdata[ATTR_W-1:0]);
      end
      if (int'(cfg_addr) == FIX_IDX) fix_d = attr_t'(cfg_wdata[ATTR_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= '0;
      attr_q  <= '0;
      fix_q   <= '0;
    end else if (cfg_we) begin
      range_q <= range_d;
      attr_q  <= attr_d;
      fix_q   <= fix_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
      assign win_lo[g] = range_q[g][CMP_BITS-1:0];
      assign win_hi[g] = range_q[g][DW-1:CMP_BITS];
    end
  endgenerate

  assign win_attr = attr_q;
  assign fix_attr = fix_q;

endmodule

// File: rtl/bwm_range_cmp.sv
module bwm_range_cmp #(
  parameter int CMP_BITS = 16
) (
  input  logic                enable,
  input  logic [CMP_BITS-1:0] tag,
  input  logic [CMP_BITS-1:0] lo,
  input  logic [CMP_BITS-1:0] hi,
  output logic                match
);

  logic above_lo;
  logic below_hi;

  assign above_lo = (tag >= lo);
  assign below_hi = (tag <= hi);
  assign match    = enable & above_lo & below_hi;

endmodule

// File: rtl/bwm_fixed_io.sv
module bwm_fixed_io
  import bwm_pkg::*;
(
  input  logic [31:0] addr,
  input  attr_t       fix,
  output logic        match,
  output space_e      space,
  output logic        d32
);

  logic in_short;
  logic in_a24;
  logic in_a32;
  logic unused_fix_bits;

  assign in_short = (addr[31:16] == SHORT_IO_TAG);
  assign in_a24   = (addr[31:24] == FIX_A24_TAG);
  assign in_a32   = (addr >= FIX_A32_LO) && (addr <= FIX_A32_HI);

  assign unused_fix_bits = fix.a32 ^ fix.post ^ fix.sup ^ fix.prog;

  always_comb begin
    match = fix.en & (in_short | in_a24 | in_a32);
    space = SPC_A32;
    d32   = 1'b0;
    if (in_short) begin
      space = SPC_A16;
      d32   = fix.d32;
    end else if (in_a24) begin
      space = SPC_A24;
    end
  end

endmodule

// File: rtl/bwm_resolve.sv
module bwm_resolve
  import bwm_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ID_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [NUM_WIN-1:0]  win_match,
  input  attr_t [NUM_WIN-1:0] win_attr,
  input  logic                fix_match,
  input  space_e              fix_space,
  input  logic                fix_d32,
  input  attr_t               fix_attr,
  output logic                hit,
  output logic [ID_W-1:0]     hit_win,
  output space_e              space,
  output logic [5:0]          am,
  output logic                d32,
  output logic                sup,
  output logic                prog,
  output logic                post
);

  logic          hit_d, hit_q;
  logic [ID_W-1:0] id_d, id_q;
  space_e        spc_d, spc_q;
  logic [5:0]    am_d, am_q;
  logic          d32_d, d32_q;
  logic          sup_d, sup_q;
  logic          prog_d, prog_q;
  logic          post_d, post_q;
  logic          pen;

  always_comb begin
    hit_d  = 1'b0;
    id_d   = '0;
    spc_d  = SPC_A16;
    d32_d  = 1'b0;
    sup_d  = 1'b0;
    prog_d = 1'b0;
    pen    = 1'b0;
    if (acc_valid) begin
      if (fix_match) begin
        hit_d  = 1'b1;
        id_d   = ID_W'(NUM_WIN);
        spc_d  = fix_space;
        d32_d  = fix_d32;
        sup_d  = fix_attr.sup;
        prog_d = fix_attr.prog;
        pen    = fix_attr.post;
      end else begin
        // walk downward so the lowest index is written last and wins
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
          if (win_match[i]) begin
            hit_d  = 1'b1;
            id_d   = ID_W'(i);
            spc_d  = win_attr[i].a32 ? SPC_A32 : SPC_A24;
            d32_d  = win_attr[i].d32;
            sup_d  = win_attr[i].sup;
            prog_d = win_attr[i].prog;
            pen    = win_attr[i].post;
          end
        end
      end
    end
    post_d = hit_d & pen & acc_write;
    am_d   = hit_d ? am_code(spc_d, sup_d, prog_d) : 6'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      id_q   <= '0;
      spc_q  <= SPC_A16;
      am_q   <= '0;
      d32_q  <= 1'b0;
      sup_q  <= 1'b0;
      prog_q <= 1'b0;
      post_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      id_q   <= id_d;
      spc_q  <= spc_d;
      am_q   <= am_d;
      d32_q  <= d32_d;
      sup_q  <= sup_d;
      prog_q <= prog_d;
      post_q <= post_d;
    end
  end

  assign hit     = hit_q;
  assign hit_win = id_q;
  assign space   = spc_q;
  assign am      = am_q;
  assign d32     = d32_q;
  assign sup     = sup_q;
  assign prog    = prog_q;
  assign post    = post_q;

endmodule

// File: rtl/bus_window_map.sv
module bus_window_map
  import bwm_pkg::*;
#(
  parameter  int NUM_WIN  = 4,
  parameter  int CMP_BITS = 16,
  localparam int CFG_AW   = $clog2(2*NUM_WIN + 1),
  localparam int ID_W     = $clog2(NUM_WIN + 1),
  localparam int DW       = 2 * CMP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_write,
  output logic              hit,
  output logic [ID_W-1:0]   hit_win,
  output logic [1:0]        vme_space,
  output logic [5:0]        vme_am,
  output logic              vme_d32,
  output logic              vme_sup,
  output logic              vme_prog,
  output logic              post_wr
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_WIN-1:0][CMP_BITS-1:0] win_lo;
  logic [NUM_WIN-1:0][CMP_BITS-1:0] win_hi;
  attr_t [NUM_WIN-1:0]              win_attr;
  attr_t                            fix_attr;
  logic [NUM_WIN-1:0]               win_match;
  logic                             fix_match;
  space_e                           fix_space;
  logic                             fix_d32;
  space_e                           out_space;

  bwm_cfg_regs #(
    .NUM_WIN (NUM_WIN),
    .CMP_BITS(CMP_BITS),
    .CFG_AW  (CFG_AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .win_attr (win_attr),
    .fix_attr (fix_attr)
  );

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      bwm_range_cmp #(.CMP_BITS(CMP_BITS)) u_cmp (
        .enable(win_attr[g].en),
        .tag   (acc_addr[31 -: CMP_BITS]),
        .lo    (win_lo[g]),
        .hi    (win_hi[g]),
        .match (win_match[g])
      );
    end
  endgenerate

  bwm_fixed_io u_fixed (
    .addr (acc_addr),
    .fix  (fix_attr),
    .match(fix_match),
    .space(fix_space),
    .d32  (fix_d32)
  );

  bwm_resolve #(
    .NUM_WIN(NUM_WIN),
    .ID_W   (ID_W)
  ) u_resolve (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .win_match(win_match),
    .win_attr (win_attr),
    .fix_match(fix_match),
    .fix_space(fix_space),
    .fix_d32  (fix_d32),
    .fix_attr (fix_attr),
    .hit      (hit),
    .hit_win  (hit_win),
    .space    (out_space),
    .am       (vme_am),
    .d32      (vme_d32),
    .sup      (vme_sup),
    .prog     (vme_prog),
    .post     (post_wr)
  );

  assign vme_space = out_space;

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int NUM_WIN = 4,
  parameter int ID_W    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic            hit,
  input logic [ID_W-1:0] hit_win,
  input logic [1:0]      vme_space,
  input logic [5:0]      vme_am,
  input logic            vme_d32,
  input logic            post_wr
);

  // R8: an idle cycle produces no hit on the next one
  assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> !hit);

  // R8: a miss carries no attributes
  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (vme_am == 6'h00 && !vme_d32 && !post_wr && hit_win == '0));

  // R7: posting only for hitting writes
  assert_post_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    post_wr |-> (hit && $past(acc_write)));

  // R4: A16 space only comes from the fixed decoder
  assert_a16_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && vme_space == 2'd0) |-> (hit_win == ID_W'(NUM_WIN)));

  // R5: the fixed A24 and A32 regions are D16
  assert_fixed_d16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_win == ID_W'(NUM_WIN) && vme_space != 2'd0) |-> !vme_d32);

  // R6: the modifier family follows the space
  assert_am_family_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((vme_space == 2'd2 && vme_am[5:3] == 3'b001) ||
             (vme_space == 2'd1 && vme_am[5:3] == 3'b111) ||
             (vme_space == 2'd0 && vme_am[5:3] == 3'b101 && vme_am[1:0] == 2'b01)));

  // R10: index stays within the decoder count
  assert_index_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_win <= ID_W'(NUM_WIN)));

endmodule

bind bus_window_map bwm_checker #(.NUM_WIN(NUM_WIN), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_write(acc_write),
  .hit      (hit),
  .hit_win  (hit_win),
  .vme_space(vme_space),
  .vme_am   (vme_am),
  .vme_d32  (vme_d32),
  .post_wr  (post_wr)
);

// File: tb/tb_bus_window_map.sv
`timescale 1ns/1ps
module tb_bus_window_map;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic        hit;
  logic [2:0]  hit_win;
  logic [1:0]  vme_space;
  logic [5:0]  vme_am;
  logic        vme_d32;
  logic        vme_sup;
  logic        vme_prog;
  logic        post_wr;

  int n_cmp = 0;
  int n_bad = 0;

  bus_window_map dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .hit(hit), .hit_win(hit_win),
    .vme_space(vme_space), .vme_am(vme_am), .vme_d32(vme_d32),
    .vme_sup(vme_sup), .vme_prog(vme_prog), .post_wr(post_wr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        hit;
    logic [2:0]  id;
    logic [1:0]  spc;
    logic [5:0]  am;
    logic        d32;
    logic        post;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 1'b1, 1'b1, 3'd0, 2'd2, 6'h0D, 1'b1, 1'b1},
    '{32'h0000_1234, 1'b0, 1'b1, 3'd0, 2'd2, 6'h0D, 1'b1, 1'b0},
    '{32'h0FFF_FFFC, 1'b1, 1'b1, 3'd0, 2'd2, 6'h0D, 1'b1, 1'b1},
    '{32'h1000_0000, 1'b1, 1'b1, 3'd1, 2'd1, 6'h3A, 1'b0, 1'b0},
    '{32'h0800_0000, 1'b0, 1'b1, 3'd0, 2'd2, 6'h0D, 1'b1, 1'b0},
    '{32'h1FFF_FFFF, 1'b0, 1'b1, 3'd1, 2'd1, 6'h3A, 1'b0, 1'b0},
    '{32'h2000_0000, 1'b1, 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0},
    '{32'h3000_0000, 1'b1, 1'b1, 3'd2, 2'd2, 6'h09, 1'b0, 1'b1},
    '{32'h3000_FFFF, 1'b0, 1'b1, 3'd2, 2'd2, 6'h09, 1'b0, 1'b0},
    '{32'h3001_0000, 1'b1, 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0},
    '{32'h2FFF_FFFF, 1'b1, 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0},
    '{32'hFFFF_0000, 1'b1, 1'b1, 3'd4, 2'd0, 6'h2D, 1'b1, 1'b1},
    '{32'hFFFF_FFFF, 1'b0, 1'b1, 3'd4, 2'd0, 6'h2D, 1'b1, 1'b0},
    '{32'hF000_0000, 1'b1, 1'b1, 3'd4, 2'd1, 6'h3D, 1'b0, 1'b1},
    '{32'hF0FF_FFFF, 1'b0, 1'b1, 3'd4, 2'd1, 6'h3D, 1'b0, 1'b0},
    '{32'hF100_0000, 1'b1, 1'b1, 3'd4, 2'd2, 6'h0D, 1'b0, 1'b1},
    '{32'hFF7F_FFFF, 1'b0, 1'b1, 3'd4, 2'd2, 6'h0D, 1'b0, 1'b0},
    '{32'hFF80_0000, 1'b1, 1'b1, 3'd3, 2'd1, 6'h3E, 1'b1, 1'b0},
    '{32'hFFFE_FFFF, 1'b1, 1'b1, 3'd3, 2'd1, 6'h3E, 1'b1, 1'b0},
    '{32'hEFFF_FFFF, 1'b1, 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one access, sample the registered result one cycle later
  task automatic access(logic [31:0] a, logic w);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_out(string tag, logic h, logic [2:0] id, logic [1:0] s,
                            logic [5:0] am, logic d, logic p);
    chk({tag, " hit"},   32'(hit),       32'(h));
    chk({tag, " win"},   32'(hit_win),   32'(id));
    chk({tag, " space"}, 32'(vme_space), 32'(s));
    chk({tag, " am"},    32'(vme_am),    32'(am));
    chk({tag, " d32"},   32'(vme_d32),   32'(d));
    chk({tag, " post"},  32'(post_wr),   32'(p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    expect_out("R8 reset", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);
    // R9 all decoders disabled after reset
    access(32'h0000_1234, 1'b1);
    expect_out("R9 reset disabled", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);
    access(32'hFFFF_0000, 1'b1);
    expect_out("R9 reset fixed off", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);

    cfg_write(4'd0, 32'h0FFF_0000); cfg_write(4'd1, 32'h1F);
    cfg_write(4'd2, 32'h1FFF_0800); cfg_write(4'd3, 32'h21);
    cfg_write(4'd4, 32'h3000_3000); cfg_write(4'd5, 32'h0B);
    cfg_write(4'd6, 32'hFFFF_FF80); cfg_write(4'd7, 32'h35);
    cfg_write(4'd8, 32'h1D);

    // table: R1 R2 R3 R4 R5 R6 R7 R10
    for (int k = 0; k < NV; k++) begin
      access(VECS[k].addr, VECS[k].wr);
      expect_out($sformatf("R1-table vec%0d", k), VECS[k].hit, VECS[k].id,
                 VECS[k].spc, VECS[k].am, VECS[k].d32, VECS[k].post);
    end

    // R8 idle cycle after a hit gives no hit
    access(32'h0000_1234, 1'b1);
    @(negedge clk);
    expect_out("R8 idle", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);

    // R3 fixed disabled: programmable window takes the short I/O address
    cfg_write(4'd8, 32'h1C);
    access(32'hFFFF_0000, 1'b1);
    expect_out("R3 fixed off win3", 1'b1, 3'd3, 2'd1, 6'h3E, 1'b1, 1'b0);
    access(32'hF000_0000, 1'b1);
    expect_out("R3 fixed off miss", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);

    // R4 short I/O at D16
    cfg_write(4'd8, 32'h19);
    access(32'hFFFF_0004, 1'b1);
    expect_out("R4 short d16", 1'b1, 3'd4, 2'd0, 6'h2D, 1'b0, 1'b1);

    // R6 program bit: A24 gets 0x3E, A16 unaffected
    cfg_write(4'd8, 32'h3D);
    access(32'hF000_0000, 1'b0);
    expect_out("R6 a24 prog", 1'b1, 3'd4, 2'd1, 6'h3E, 1'b0, 1'b0);
    chk("R6 prog out", 32'(vme_prog), 32'd1);
    chk("R6 sup out", 32'(vme_sup), 32'd1);
    access(32'hFFFF_0000, 1'b0);
    expect_out("R6 a16 prog ignored", 1'b1, 3'd4, 2'd0, 6'h2D, 1'b1, 1'b0);

    // R2 disabled window 0 yields to window 1
    cfg_write(4'd1, 32'h1E);
    access(32'h0800_0000, 1'b0);
    expect_out("R2 w0 off", 1'b1, 3'd1, 2'd1, 6'h3A, 1'b0, 1'b0);
    chk("R2 prog out", 32'(vme_prog), 32'd1);
    chk("R2 sup out", 32'(vme_sup), 32'd0);

    // R1 inverted window never hits
    cfg_write(4'd4, 32'h4000_5000);
    access(32'h4800_0000, 1'b1);
    expect_out("R1 inverted", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);
    access(32'h3000_0000, 1'b1);
    expect_out("R1 old range gone", 1'b0, 3'd0, 2'd0, 6'h00, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule